// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Run-Time Size and Bypass Windows

This block is a unified instruction/data cache placed between a CPU-side word port and a main-memory port. Lines are 16 bytes and each memory address has exactly one possible line (direct mapping). Every store is sent on to memory. A read that misses in a cacheable region fetches the whole line as four single-word memory reads. Once the line is filled, the read is answered from the cache.

A three-bit control input carries the capacity field and a posted-store enable. The capacity field selects off, 4 KB (256 lines) or 8 KB (512 lines). Two 32-bit window words each describe a 4 KB-granular address range that is never cached. Reads inside a window are fetched as single words and returned directly. Accesses inside a window never fill or change a line.

On the CPU side, the CPU raises `cpu_req` and holds it with its address until `cpu_ack` pulses. On the memory side, the block raises `mem_req` and holds it until the memory answers with a one-cycle `mem_ack`. Only one memory transaction is open at a time.

Top module: `cwt_cache`

## Requirements
- R1: The capacity field `cfg_ctrl[2:1]` selects the size. 2'b00 (and the unused 2'b10) turn caching off, so every read becomes one single-word memory read. 2'b01 gives 256 lines indexed by address bits [11:4]. 2'b11 gives 512 lines indexed by bits [12:4].
- R2: A read hit is acknowledged in the same cycle as the request, returns the cached word, and starts no memory transaction.
- R3: A cacheable read miss issues four word reads to the line base +0, +4, +8 and +12, in that order. The request is then acknowledged from the filled line.
- R4: A hit needs the indexed line to be valid and its stored tag to equal the request's upper address bits. A second address that maps to the same line evicts the first.
- R5: Every store produces exactly one memory write with the store's address and data. On a hit, the cached word is also updated.
- R6: A store that misses does not allocate a line, so a later read of that address misses.
- R7: Window word bits [15:0] hold start>>12 and bits [31:16] hold end>>12. An address is inside a window when start <= addr>>12 < end. The end page is excluded, and a window whose start equals its end matches nothing.
- R8: A read inside a window is one single-word memory read returned directly to the CPU, even if a valid line holds that address. It never fills a line, and a store inside a window never updates one.
- R9: Setting the capacity field to off, or changing it from 4 KB to 8 KB, invalidates every line.
- R10: When `cfg_ctrl[3]` is 1, a store is acknowledged in the cycle it is presented and its memory write drains afterwards. Read hits are served while it drains. Any access that needs memory waits until the write completes.
- R11: The memory port has at most one open transaction. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`.
- R12: After reset no line is valid, and neither `mem_req` nor `cpu_ack` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ctrl | input | 3 | Bits [2:1] capacity field, bit 3 posted-store enable |
| nc_win0 | input | 32 | First non-cacheable window: end page [31:16], start page [15:0] |
| nc_win1 | input | 32 | Second non-cacheable window, same layout |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | CPU byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle memory completion |

## Verification
The hardest case to reach is a read hit that must be answered while a posted store is still waiting on a slow memory. The bench sets a memory latency of several cycles and enables the posted-store bit. It then issues a store that hits a line it has just filled, and follows at once with a read of the same word. That read must come back in zero wait cycles with the new data, while `mem_req` is still high. A following miss is then checked to reach memory only after the store's write. Stale lines after a capacity change are exposed by filling in 4 KB mode, moving to 8 KB, and counting the memory reads a repeat access causes.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int PAGE_SH    = 12;
    localparam int PAGE_W     = ADDR_W - PAGE_SH;
    localparam int LINE_WORDS = 4;
    localparam int OFS_W      = $clog2(LINE_WORDS);
    localparam int BYTE_SH    = $clog2(WORD_W / 8);
    localparam int LINE_SH    = OFS_W + BYTE_SH;

    typedef enum logic [1:0] {SZ_OFF, SZ_HALF, SZ_FULL} size_e;

    typedef enum logic [2:0] {ST_IDLE, ST_FILL, ST_RD, ST_WR, ST_POST} state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } op_t;

    function automatic size_e decode_size(input logic [1:0] field);
        case (field)
            2'b01:   return SZ_HALF;
            2'b11:   return SZ_FULL;
            default: return SZ_OFF;
        endcase
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] win,
                                       input logic [PAGE_W-1:0] page);
        logic [PAGE_W-1:0] lo;
        logic [PAGE_W-1:0] hi;
        lo = PAGE_W'(win[15:0]);
        hi = PAGE_W'(win[31:16]);
        return (page >= lo) && (page < hi);
    endfunction
endpackage

// File: rtl/cwt_nc_decode.sv
module cwt_nc_decode
    import cwt_pkg::*;
#(
    parameter int NWIN = 2
) (
    input  logic [NWIN-1:0][ADDR_W-1:0] win_cfg,
    input  logic [PAGE_W-1:0]           page,
    output logic                        in_nc
);
    logic [NWIN-1:0] match;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        assign match[g] = in_window(win_cfg[g], page);

        always_comb begin
            if (win_cfg[g][15:0] >= win_cfg[g][31:16])
                assert_empty_window_R7: assert (!match[g]);
        end
    end

    assign in_nc = |match;
endmodule

// File: rtl/cwt_line_store.sv
module cwt_line_store
    import cwt_pkg::*;
#(
    parameter int LINES = 512,
    parameter int TAG_W = 20,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_all,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [OFS_W-1:0]  lk_ofs,
    output logic              lk_valid,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [WORD_W-1:0] lk_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              set_valid,
    input  logic [TAG_W-1:0]  set_tag
);
    localparam int SLOTS = LINES * LINE_WORDS;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [WORD_W-1:0] word_q [SLOTS];

    always_ff @(posedge clk) begin
        if (rst || clr_all)
            valid_q <= '0;
        else if (set_en)
            valid_q[set_idx] <= set_valid;
    end

    always_ff @(posedge clk) begin
        if (set_en && set_valid)
            tag_q[set_idx] <= set_tag;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            word_q[{wr_idx, wr_ofs}] <= wr_data;
    end

    assign lk_valid = valid_q[lk_idx];
    assign lk_tag   = tag_q[lk_idx];
    assign lk_word  = word_q[{lk_idx, lk_ofs}];

    assert_clear_all_R9: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (valid_q == '0));
endmodule

// File: rtl/cwt_cache.sv
module cwt_cache
    import cwt_pkg::*;
#(
    parameter int LINES_FULL = 512,
    parameter int NWIN       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:1]        cfg_ctrl,
    input  logic [31:0]       nc_win0,
    input  logic [31:0]       nc_win1,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack
);
    localparam int IDX_FULL = $clog2(LINES_FULL);
    localparam int IDX_HALF = IDX_FULL - 1;
    localparam int TAG_W    = ADDR_W - LINE_SH - IDX_HALF;
    localparam logic [OFS_W-1:0] LAST_WORD = OFS_W'(LINE_WORDS - 1);

    size_e  sz, prev_sz_q;
    state_e state_q;
    op_t    op_q;
    logic [OFS_W-1:0]    fill_cnt_q;
    logic [IDX_FULL-1:0] fill_idx_q, lk_idx;
    logic                wbuf_en, in_nc, cacheable, hit, clr_all;
    logic                lk_valid;
    logic [TAG_W-1:0]    lk_tag, cpu_tag;
    logic [WORD_W-1:0]   lk_word;
    logic                idle_req, start_fill, fill_done;
    logic                wr_en, set_en;
    logic [NWIN-1:0][ADDR_W-1:0] wins;

    assign sz      = decode_size(cfg_ctrl[2:1]);
    assign wbuf_en = cfg_ctrl[3];
    assign wins    = {nc_win1, nc_win0};
    assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];

    cwt_nc_decode #(.NWIN(NWIN)) u_nc (
        .win_cfg (wins),
        .page    (cpu_addr[ADDR_W-1:PAGE_SH]),
        .in_nc   (in_nc)
    );

    always_comb begin
        if (sz == SZ_FULL)
            lk_idx = cpu_addr[LINE_SH +: IDX_FULL];
        else
            lk_idx = {1'b0, cpu_addr[LINE_SH +: IDX_HALF]};
    end

    assign cacheable = (sz != SZ_OFF) && !in_nc;
    assign hit       = cacheable && lk_valid && (lk_tag == cpu_tag);
    assign clr_all   = (sz == SZ_OFF) || (prev_sz_q == SZ_HALF && sz == SZ_FULL);

    assign idle_req   = cpu_req && (state_q == ST_IDLE);
    assign start_fill = idle_req && !cpu_we && !hit && cacheable;
    assign fill_done  = (state_q == ST_FILL) && mem_ack && (fill_cnt_q == LAST_WORD);
    assign wr_en      = ((state_q == ST_FILL) && mem_ack) || (idle_req && cpu_we && hit);
    assign set_en     = start_fill || fill_done;

    cwt_line_store #(.LINES(LINES_FULL), .TAG_W(TAG_W), .IDX_W(IDX_FULL)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr_all   (clr_all),
        .lk_idx    (lk_idx),
        .lk_ofs    (cpu_addr[BYTE_SH +: OFS_W]),
        .lk_valid  (lk_valid),
        .lk_tag    (lk_tag),
        .lk_word   (lk_word),
        .wr_en     (wr_en),
        .wr_idx    ((state_q == ST_FILL) ? fill_idx_q : lk_idx),
        .wr_ofs    ((state_q == ST_FILL) ? fill_cnt_q : cpu_addr[BYTE_SH +: OFS_W]),
        .wr_data   ((state_q == ST_FILL) ? mem_rdata : cpu_wdata),
        .set_en    (set_en),
        .set_idx   ((state_q == ST_FILL) ? fill_idx_q : lk_idx),
        .set_valid (state_q == ST_FILL),
        .set_tag   (op_q.addr[ADDR_W-1 -: TAG_W])
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            op_q       <= '0;
            fill_cnt_q <= '0;
            fill_idx_q <= '0;
            prev_sz_q  <= SZ_OFF;
        end else begin
            prev_sz_q <= sz;
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req && cpu_we) begin
                        op_q    <= '{addr: cpu_addr, data: cpu_wdata};
                        state_q <= wbuf_en ? ST_POST : ST_WR;
                    end else if (cpu_req && !hit) begin
                        op_q       <= '{addr: cpu_addr, data: '0};
                        fill_cnt_q <= '0;
                        fill_idx_q <= lk_idx;
                        state_q    <= cacheable ? ST_FILL : ST_RD;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        fill_cnt_q <= fill_cnt_q + 1'b1;
                        if (fill_cnt_q == LAST_WORD)
                            state_q <= ST_IDLE;
                    end
                end
                ST_RD, ST_WR, ST_POST: begin
                    if (mem_ack)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (state_q != ST_IDLE);
    assign mem_we    = (state_q == ST_WR) || (state_q == ST_POST);
    assign mem_addr  = (state_q == ST_FILL)
                     ? {op_q.addr[ADDR_W-1:LINE_SH], fill_cnt_q, {BYTE_SH{1'b0}}}
                     : op_q.addr;
    assign mem_wdata = op_q.data;

    assign cpu_ack = (cpu_req && !cpu_we && hit &&
                      (state_q == ST_IDLE || state_q == ST_POST))
                   || (idle_req && cpu_we && wbuf_en)
                   || ((state_q == ST_RD || state_q == ST_WR) && mem_ack);
    assign cpu_rdata = (state_q == ST_RD) ? mem_rdata : lk_word;

    assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (rst)
        (idle_req && !cpu_we && hit) |=> !mem_req);

    assert_fill_len_R3: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> (state_q == ST_IDLE && !mem_req));

    assert_write_through_R5: assert property (@(posedge clk) disable iff (rst)
        (idle_req && cpu_we) |=> (mem_req && mem_we &&
            mem_addr == $past(cpu_addr) && mem_wdata == $past(cpu_wdata)));

    assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (idle_req && !cpu_we && in_nc) |=> (state_q == ST_RD));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/sim_cwt_cache.sv
module sim_cwt_cache;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:1]  cfg_ctrl;
    logic [31:0] nc_win0, nc_win1;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_ack;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack;

    always #10 clk = ~clk;

    cwt_cache u0 (
        .clk(clk), .rst(rst), .cfg_ctrl(cfg_ctrl), .nc_win0(nc_win0), .nc_win1(nc_win1),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int tx_count = 0;
    int mem_lat  = 0;
    int wcnt     = 0;
    logic [31:0] log_addr [256];
    logic        log_we   [256];
    logic [31:0] log_data [256];
    logic [31:0] act_mem [logic [31:0]];
    logic [31:0] exp_mem [logic [31:0]];

    function automatic logic [31:0] seed_word(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [31:0] a);
        if (exp_mem.exists(a)) return exp_mem[a];
        return seed_word(a);
    endfunction

    // memory responder: one-cycle ack after mem_lat idle negedges
    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wcnt    = 0;
            end else if (mem_req && !rst) begin
                if (wcnt >= mem_lat) begin
                    log_addr[tx_count % 256] = mem_addr;
                    log_we[tx_count % 256]   = mem_we;
                    log_data[tx_count % 256] = mem_wdata;
                    if (mem_we) act_mem[mem_addr] = mem_wdata;
                    else mem_rdata = act_mem.exists(mem_addr) ? act_mem[mem_addr]
                                                                : seed_word(mem_addr);
                    mem_ack  = 1'b1;
                    wcnt     = 0;
                    tx_count = tx_count + 1;
                end else begin
                    wcnt = wcnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int waits, output int ntx);
        int t0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        waits = 0;
        #1;
        t0 = tx_count;
        while (!cpu_ack && waits < 2000) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #1;
        ntx = tx_count - t0;
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  ntx;
    } vec_t;

    // 8 KB mode, no windows, no posted stores
    localparam vec_t VECS [10] = '{
        '{1'b0, 32'h1000_0040, 32'h0,          4'd4},
        '{1'b0, 32'h1000_0044, 32'h0,          4'd0},
        '{1'b1, 32'h1000_0048, 32'hCAFE_0001,  4'd1},
        '{1'b0, 32'h1000_0048, 32'h0,          4'd0},
        '{1'b0, 32'h2000_0040, 32'h0,          4'd4},
        '{1'b0, 32'h1000_0048, 32'h0,          4'd4},
        '{1'b1, 32'h3000_0100, 32'h1234_ABCD,  4'd1},
        '{1'b0, 32'h3000_0100, 32'h0,          4'd4},
        '{1'b0, 32'h1000_1040, 32'h0,          4'd4},
        '{1'b0, 32'h1000_0040, 32'h0,          4'd0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd, a1;
        int waits, ntx, base;
        rst = 1'b1; cfg_ctrl = 3'b011; nc_win0 = '0; nc_win1 = '0;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        idle_cycles(5);
        rst = 1'b0;
        #1;
        chk(mem_req == 1'b0, "R12 mem_req after reset", 32'(mem_req), 32'h0);
        chk(cpu_ack == 1'b0, "R12 cpu_ack after reset", 32'(cpu_ack), 32'h0);

        // table walk
        for (int i = 0; i < 10; i++) begin
            base = tx_count;
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, waits, ntx);
            if (VECS[i].we) begin
                exp_mem[VECS[i].addr] = VECS[i].wdata;
                chk(ntx == 1, "R5 store tx count", 32'(ntx), 32'd1);
                chk(log_we[base % 256] && log_addr[base % 256] == VECS[i].addr &&
                    log_data[base % 256] == VECS[i].wdata, "R5 store forwarded",
                    log_data[base % 256], VECS[i].wdata);
            end else begin
                chk(rd == exp_rd(VECS[i].addr), "R4 read data", rd, exp_rd(VECS[i].addr));
                if (VECS[i].ntx == 0)
                    chk(ntx == 0 && waits == 0, "R2 hit no memory, zero wait", 32'(ntx), 32'd0);
                else
                    chk(ntx == 4, "R3 miss refills line", 32'(ntx), 32'd4);
            end
            if (i == 0)
                for (int k = 0; k < 4; k++)
                    chk(log_addr[(base + k) % 256] == 32'h1000_0040 + 32'(4 * k),
                        "R3 refill order", log_addr[(base + k) % 256],
                        32'h1000_0040 + 32'(4 * k));
            if (i == 7)
                chk(ntx == 4, "R6 store miss did not allocate", 32'(ntx), 32'd4);
        end

        // R1: off mode
        cfg_ctrl = 3'b000;
        idle_cycles(2);
        access(1'b0, 32'h1000_0040, 32'h0, rd, waits, ntx);
        chk(ntx == 1 && rd == exp_rd(32'h1000_0040), "R1 off mode single read", 32'(ntx), 32'd1);
        access(1'b0, 32'h1000_0040, 32'h0, rd, waits, ntx);
        chk(ntx == 1, "R1 off mode no fill", 32'(ntx), 32'd1);

        // R1: 4 KB mode aliases bit 12
        cfg_ctrl = 3'b001;
        idle_cycles(2);
        access(1'b0, 32'h1000_0040, 32'h0, rd, waits, ntx);
        chk(ntx == 4, "R1 half mode fill", 32'(ntx), 32'd4);
        access(1'b0, 32'h1000_1040, 32'h0, rd, waits, ntx);
        chk(ntx == 4 && rd == exp_rd(32'h1000_1040), "R1 half mode conflict", 32'(ntx), 32'd4);
        access(1'b0, 32'h1000_0044, 32'h0, rd, waits, ntx);
        chk(ntx == 4, "R4 evicted line misses", 32'(ntx), 32'd4);
        access(1'b0, 32'h1000_0048, 32'h0, rd, waits, ntx);
        chk(ntx == 0 && rd == exp_rd(32'h1000_0048), "R2 half mode hit", 32'(ntx), 32'd0);

        // R9: 4 KB -> 8 KB invalidates; off invalidates
        cfg_ctrl = 3'b011;
        idle_cycles(2);
        access(1'b0, 32'h1000_0040, 32'h0, rd, waits, ntx);
        chk(ntx == 4, "R9 grow invalidates", 32'(ntx), 32'd4);
        cfg_ctrl = 3'b000;
        idle_cycles(2);
        cfg_ctrl = 3'b011;
        idle_cycles(2);
        access(1'b0, 32'h1000_0040, 32'h0, rd, waits, ntx);
        chk(ntx == 4, "R9 off invalidates", 32'(ntx), 32'd4);

        // R7 / R8 windows
        access(1'b0, 32'h0800_2000, 32'h0, rd, waits, ntx);
        chk(ntx == 4, "R7 end page excluded", 32'(ntx), 32'd4);
        nc_win0 = {16'h8002, 16'h8000};
        nc_win1 = {16'h9000, 16'h9000};
        idle_cycles(1);
        access(1'b0, 32'h0800_1FFC, 32'h0, rd, waits, ntx);
        chk(ntx == 1 && rd == exp_rd(32'h0800_1FFC), "R8 window read direct", 32'(ntx), 32'd1);
        access(1'b0, 32'h0800_1FFC, 32'h0, rd, waits, ntx);
        chk(ntx == 1, "R8 window never fills", 32'(ntx), 32'd1);
        access(1'b1, 32'h0800_0010, 32'hBEEF_0010, rd, waits, ntx);
        exp_mem[32'h0800_0010] = 32'hBEEF_0010;
        access(1'b0, 32'h0800_0010, 32'h0, rd, waits, ntx);
        chk(ntx == 1 && rd == 32'hBEEF_0010, "R8 window store and reload", rd, 32'hBEEF_0010);
        access(1'b0, 32'h07FF_FFFC, 32'h0, rd, waits, ntx);
        chk(ntx == 4, "R7 below start cached", 32'(ntx), 32'd4);
        access(1'b0, 32'h0800_2000, 32'h0, rd, waits, ntx);
        chk(ntx == 0, "R7 end page still cached", 32'(ntx), 32'd0);
        access(1'b0, 32'h0900_0000, 32'h0, rd, waits, ntx);
        chk(ntx == 4, "R7 empty window matches nothing", 32'(ntx), 32'd4);
        nc_win0 = {16'h8003, 16'h8000};
        idle_cycles(1);
        access(1'b0, 32'h0800_2000, 32'h0, rd, waits, ntx);
        chk(ntx == 1 && rd == exp_rd(32'h0800_2000), "R8 window bypasses valid line",
            32'(ntx), 32'd1);
        nc_win0 = '0; nc_win1 = '0;

        // R10 / R11 posted store with slow memory
        cfg_ctrl = 3'b111;
        mem_lat  = 4;
        idle_cycles(2);
        access(1'b0, 32'h4000_0000, 32'h0, rd, waits, ntx);
        base = tx_count;
        access(1'b1, 32'h4000_0004, 32'h0000_0077, rd, waits, ntx);
        exp_mem[32'h4000_0004] = 32'h0000_0077;
        chk(waits == 0, "R10 posted store acked at once", 32'(waits), 32'd0);
        chk(mem_req && mem_we, "R10 write drains after ack", 32'(mem_req), 32'd1);
        a1 = mem_addr;
        @(negedge clk);
        #1;
        chk(mem_req && mem_addr == a1 && mem_addr == 32'h4000_0004, "R11 request held",
            mem_addr, 32'h4000_0004);
        access(1'b0, 32'h4000_0004, 32'h0, rd, waits, ntx);
        chk(waits == 0 && rd == 32'h0000_0077, "R10 hit served while draining", rd,
            32'h0000_0077);
        access(1'b0, 32'h5000_0000, 32'h0, rd, waits, ntx);
        chk(rd == exp_rd(32'h5000_0000), "R3 miss after drain data", rd, exp_rd(32'h5000_0000));
        chk(log_we[base % 256] && log_data[base % 256] == 32'h0000_0077,
            "R10 store reaches memory first", log_data[base % 256], 32'h0000_0077);
        chk(!log_we[(base + 1) % 256] && log_addr[(base + 1) % 256] == 32'h5000_0000,
            "R11 fill follows write", log_addr[(base + 1) % 256], 32'h5000_0000);
        mem_lat = 0;

        idle_cycles(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule